// File: doc/BRIEF.md
# Coprocessor Channel Register Bank

This block is the register front end of a four-channel coprocessor. A simple synchronous bus reads and writes a set of global registers: a control word, a pending-completion status word, a channel-enable word, a context pointer and a read-only capability word. Each channel also has its own command pointer, semaphore and status registers, placed at a fixed 0x40-byte stride. Both kinds of status register have a companion address at +8 that clears bits by writing ones.

The channel sequencers sit outside this block. Each one sends a one-cycle completion pulse. The pulse sets that channel's bit in the global pending word and in its own status register, and it uses up one count of the channel's semaphore. The interrupt output is high while any pending channel has its enable bit set in the low bits of the control word.

Software sets up a channel in two steps. It loads the command pointer, then writes a count to the semaphore. On an interrupt it reads the pending word and clears the bits it has serviced.

Top module: `cop_regbank`

## Requirements
- R1: After reset every register reads zero except the capability word, and `irq_o` is low.
- R2: The control word at 0x00 and the context pointer at 0x50 store all 32 bits. The channel-enable word at 0x20 stores bits [7:0] only, and its upper bits read zero. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R3: The capability word at 0x40 reads the parameter `CAP_VALUE`: bit 0 means AES-128, bit 16 means SHA-1 and bit 18 means SHA-256. Writes to 0x40 have no effect.
- R4: Channel n's command pointer sits at 0x100 + 0x40·n. It is a 32-bit read/write register that is independent of the other channels.
- R5: A completion pulse on `done_i[n]` sets bit n of the pending word at 0x10. It also sets bit 0 of channel n's status register at 0x120 + 0x40·n.
- R6: A write to 0x18 clears exactly those pending bits that are ones in the written value. Writing 0xFFFFFFFF clears them all. The per-channel status registers are not affected.
- R7: Writing a 1 in bit 0 at 0x128 + 0x40·n clears channel n's status bit. It leaves the pending word and the other channels unchanged.
- R8: If a completion pulse and a clear of the same bit arrive in the same cycle, the bit stays set. This holds for both the pending word and the channel status register.
- R9: `irq_o` is the OR over n of (pending bit n AND control bit n). It changes in the same cycle as the registers it depends on.
- R10: Channel n's semaphore at 0x110 + 0x40·n is 8 bits wide. A write adds the low byte of the written value, modulo 256. A completion pulse subtracts one, but only when the value before the pulse is nonzero. A write and a pulse in the same cycle combine.
- R11: Reads of unmapped or unaligned offsets return zero, and writes to them change nothing. Both clear addresses (0x18 and 0x128 + 0x40·n) read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; the write is committed on the clock edge |
| bus_rd | input | 1 | Read strobe; data is returned on the next cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| done_i | input | NCH | One-cycle completion pulse per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after four corner cases.

- **Pulse and clear in the same cycle.** The bench hits the same bit with both at once. A design that lets the clear win would drop a completion, and the interrupt would never arrive.
- **Partial clear masks.** The bench clears only some pending bits. A design that clears the whole word, or that also clears the channel status, fails the readback.
- **Semaphore limits.** The bench drives the semaphore to wrap at 256, pulses it again at zero, and writes it in the same cycle as a pulse that finds it at zero. A design that underflows, saturates, or decrements on the incoming value instead of the held one reads back the wrong count.
- **Decode edges.** The bench probes unmapped, unaligned and past-the-last-channel addresses, plus the write-only clear addresses. Sloppy decoding either aliases these onto real registers or leaks nonzero data.

// File: rtl/cop_regbank_pkg.sv
package cop_regbank_pkg;

    // Global register byte offsets
    localparam int unsigned OFF_CTRL  = 'h000;
    localparam int unsigned OFF_PEND  = 'h010;
    localparam int unsigned OFF_PCLR  = 'h018;
    localparam int unsigned OFF_CHEN  = 'h020;
    localparam int unsigned OFF_CAP   = 'h040;
    localparam int unsigned OFF_CTX   = 'h050;

    // Per-channel window: base plus channel index times stride
    localparam int unsigned CH_BASE   = 'h100;
    localparam int unsigned CH_STRIDE = 'h040;
    localparam int unsigned SUB_CMD   = 'h00;
    localparam int unsigned SUB_SEM   = 'h10;
    localparam int unsigned SUB_STAT  = 'h20;
    localparam int unsigned SUB_SCLR  = 'h28;

    localparam int SEM_W = 8;

    typedef struct packed {
        logic ctrl;
        logic pend;
        logic pclr;
        logic chen;
        logic cap;
        logic ctx;
    } glob_hit_t;

    typedef struct packed {
        logic [31:0]      cmd;
        logic [SEM_W-1:0] sem;
        logic             stat;
    } chan_state_t;

endpackage

// File: rtl/cop_addr_decode.sv
module cop_addr_decode
    import cop_regbank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NCH    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output glob_hit_t         ghit,
    output logic [NCH-1:0]    hit_cmd,
    output logic [NCH-1:0]    hit_sem,
    output logic [NCH-1:0]    hit_stat,
    output logic [NCH-1:0]    hit_sclr,
    output logic              any_hit
);

    always_comb begin
        ghit.ctrl = (addr == ADDR_W'(OFF_CTRL));
        ghit.pend = (addr == ADDR_W'(OFF_PEND));
        ghit.pclr = (addr == ADDR_W'(OFF_PCLR));
        ghit.chen = (addr == ADDR_W'(OFF_CHEN));
        ghit.cap  = (addr == ADDR_W'(OFF_CAP));
        ghit.ctx  = (addr == ADDR_W'(OFF_CTX));
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam int unsigned BASE_N = CH_BASE + n * CH_STRIDE;
        assign hit_cmd[n]  = (addr == ADDR_W'(BASE_N + SUB_CMD));
        assign hit_sem[n]  = (addr == ADDR_W'(BASE_N + SUB_SEM));
        assign hit_stat[n] = (addr == ADDR_W'(BASE_N + SUB_STAT));
        assign hit_sclr[n] = (addr == ADDR_W'(BASE_N + SUB_SCLR));
    end

    assign any_hit = (|ghit) | (|hit_cmd) | (|hit_sem) | (|hit_stat) | (|hit_sclr);

endmodule

// File: rtl/cop_chan_regs.sv
module cop_chan_regs
    import cop_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    input  logic             sel_cmd,
    input  logic             sel_sem,
    input  logic             sel_sclr,
    input  logic             done_i,
    output logic [31:0]      cmd_o,
    output logic [SEM_W-1:0] sem_o,
    output logic             stat_o
);

    chan_state_t st_d, st_q;

    always_comb begin
        logic [SEM_W-1:0] inc;
        logic [SEM_W-1:0] dec;
        st_d = st_q;
        if (wr_en && sel_cmd) begin
            st_d.cmd = wdata;
        end
        inc = (wr_en && sel_sem) ? wdata[SEM_W-1:0] : '0;
        dec = (done_i && (st_q.sem != '0)) ? SEM_W'(1) : '0;
        st_d.sem = st_q.sem + inc - dec;
        // a pulse in the same cycle as a clear wins
        if (wr_en && sel_sclr && wdata[0]) begin
            st_d.stat = 1'b0;
        end
        if (done_i) begin
            st_d.stat = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o  = st_q.cmd;
    assign sem_o  = st_q.sem;
    assign stat_o = st_q.stat;

    p_stat_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> stat_o);

    p_sem_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_o == '0 && !(wr_en && sel_sem)) |=> (sem_o == '0));

    p_sclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_sclr && wdata[0] && !done_i) |=> !stat_o);

endmodule

// File: rtl/cop_regbank.sv
module cop_regbank
    import cop_regbank_pkg::*;
#(
    parameter int          NCH       = 4,
    parameter int          ADDR_W    = 12,
    parameter int          CHEN_W    = 8,
    parameter logic [31:0] CAP_VALUE = 32'h0005_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    done_i,
    output logic              irq_o
);

    typedef struct packed {
        logic [31:0]     ctrl;
        logic [CHEN_W-1:0] chen;
        logic [31:0]     ctx;
        logic [NCH-1:0]  pend;
        logic [31:0]     rdata;
    } glob_t;

    glob_t st_d, st_q;

    glob_hit_t      ghit;
    logic [NCH-1:0] hit_cmd, hit_sem, hit_stat, hit_sclr;
    logic           any_hit;

    logic [31:0]      ch_cmd  [NCH];
    logic [SEM_W-1:0] ch_sem  [NCH];
    logic [NCH-1:0]   ch_stat;

    cop_addr_decode #(
        .ADDR_W (ADDR_W),
        .NCH    (NCH)
    ) u_dec (
        .addr     (bus_addr),
        .ghit     (ghit),
        .hit_cmd  (hit_cmd),
        .hit_sem  (hit_sem),
        .hit_stat (hit_stat),
        .hit_sclr (hit_sclr),
        .any_hit  (any_hit)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        cop_chan_regs u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr),
            .wdata    (bus_wdata),
            .sel_cmd  (hit_cmd[n]),
            .sel_sem  (hit_sem[n]),
            .sel_sclr (hit_sclr[n]),
            .done_i   (done_i[n]),
            .cmd_o    (ch_cmd[n]),
            .sem_o    (ch_sem[n]),
            .stat_o   (ch_stat[n])
        );
    end

    always_comb begin
        logic [31:0]    rd_mux;
        logic [NCH-1:0] clr_mask;
        st_d = st_q;

        if (bus_wr && ghit.ctrl) st_d.ctrl = bus_wdata;
        if (bus_wr && ghit.chen) st_d.chen = bus_wdata[CHEN_W-1:0];
        if (bus_wr && ghit.ctx)  st_d.ctx  = bus_wdata;

        clr_mask  = (bus_wr && ghit.pclr) ? bus_wdata[NCH-1:0] : '0;
        st_d.pend = (st_q.pend & ~clr_mask) | done_i;

        rd_mux = '0;
        if (ghit.ctrl) rd_mux |= st_q.ctrl;
        if (ghit.pend) rd_mux |= 32'(st_q.pend);
        if (ghit.chen) rd_mux |= 32'(st_q.chen);
        if (ghit.cap)  rd_mux |= CAP_VALUE;
        if (ghit.ctx)  rd_mux |= st_q.ctx;
        for (int n = 0; n < NCH; n++) begin
            if (hit_cmd[n])  rd_mux |= ch_cmd[n];
            if (hit_sem[n])  rd_mux |= 32'(ch_sem[n]);
            if (hit_stat[n]) rd_mux |= 32'(ch_stat[n]);
        end
        if (bus_rd) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq_o     = |(st_q.pend & st_q.ctrl[NCH-1:0]);

    p_pend_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_i) |=> ((st_q.pend & $past(done_i)) == $past(done_i)));

    p_pclr_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ghit.pclr) |=>
            ((st_q.pend & $past(bus_wdata[NCH-1:0] & ~done_i)) == '0));

    p_cap_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ghit.cap) |=> (bus_rdata == CAP_VALUE));

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !any_hit) |=> (bus_rdata == '0));

    p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend == '0) |-> !irq_o);

    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && ghit.ctrl) |=> $stable(st_q.ctrl));

endmodule

// File: tb/cop_regbank_bench.sv
module cop_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam logic [31:0] CAP = 32'h0005_0001;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_PL  = 2'd2;
    localparam logic [1:0] OP_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 53;
    localparam vec_t VECS [NVEC] = '{
        '{OP_RD,  12'h040, 32'h0,         32'h0005_0001, 4'd3},  // R3
        '{OP_WR,  12'h040, 32'h0000_1234, 32'h0,         4'd3},  // R3
        '{OP_RD,  12'h040, 32'h0,         32'h0005_0001, 4'd3},  // R3
        '{OP_WR,  12'h000, 32'h00C0_000F, 32'h0,         4'd2},  // R2
        '{OP_RD,  12'h000, 32'h0,         32'h00C0_000F, 4'd2},  // R2
        '{OP_WR,  12'h020, 32'hFFFF_FFFF, 32'h0,         4'd2},  // R2
        '{OP_RD,  12'h020, 32'h0,         32'h0000_00FF, 4'd2},  // R2
        '{OP_WR,  12'h050, 32'hFFFF_0000, 32'h0,         4'd2},  // R2
        '{OP_RD,  12'h050, 32'h0,         32'hFFFF_0000, 4'd2},  // R2
        '{OP_WR,  12'h140, 32'hA5A5_0040, 32'h0,         4'd4},  // R4
        '{OP_RD,  12'h140, 32'h0,         32'hA5A5_0040, 4'd4},  // R4
        '{OP_RD,  12'h100, 32'h0,         32'h0,         4'd4},  // R4
        '{OP_WR,  12'h1C0, 32'hDEAD_BEEF, 32'h0,         4'd4},  // R4
        '{OP_RD,  12'h1C0, 32'h0,         32'hDEAD_BEEF, 4'd4},  // R4
        '{OP_PL,  12'h000, 32'h5,         32'h0,         4'd5},  // R5
        '{OP_RD,  12'h010, 32'h0,         32'h5,         4'd5},  // R5
        '{OP_RD,  12'h120, 32'h0,         32'h1,         4'd5},  // R5
        '{OP_RD,  12'h160, 32'h0,         32'h0,         4'd5},  // R5
        '{OP_RD,  12'h1A0, 32'h0,         32'h1,         4'd5},  // R5
        '{OP_IRQ, 12'h000, 32'h0,         32'h1,         4'd9},  // R9
        '{OP_WR,  12'h000, 32'h00C0_0002, 32'h0,         4'd9},  // R9
        '{OP_IRQ, 12'h000, 32'h0,         32'h0,         4'd9},  // R9
        '{OP_PL,  12'h000, 32'h2,         32'h0,         4'd9},  // R9
        '{OP_IRQ, 12'h000, 32'h0,         32'h1,         4'd9},  // R9
        '{OP_RD,  12'h010, 32'h0,         32'h7,         4'd5},  // R5
        '{OP_WR,  12'h018, 32'h4,         32'h0,         4'd6},  // R6
        '{OP_RD,  12'h010, 32'h0,         32'h3,         4'd6},  // R6
        '{OP_RD,  12'h1A0, 32'h0,         32'h1,         4'd6},  // R6
        '{OP_WR,  12'h128, 32'h1,         32'h0,         4'd7},  // R7
        '{OP_RD,  12'h120, 32'h0,         32'h0,         4'd7},  // R7
        '{OP_RD,  12'h010, 32'h0,         32'h3,         4'd7},  // R7
        '{OP_RD,  12'h160, 32'h0,         32'h1,         4'd7},  // R7
        '{OP_WR,  12'h018, 32'hFFFF_FFFF, 32'h0,         4'd6},  // R6
        '{OP_RD,  12'h010, 32'h0,         32'h0,         4'd6},  // R6
        '{OP_IRQ, 12'h000, 32'h0,         32'h0,         4'd6},  // R6
        '{OP_WR,  12'h110, 32'h3,         32'h0,         4'd10}, // R10
        '{OP_RD,  12'h110, 32'h0,         32'h3,         4'd10}, // R10
        '{OP_PL,  12'h000, 32'h1,         32'h0,         4'd10}, // R10
        '{OP_RD,  12'h110, 32'h0,         32'h2,         4'd10}, // R10
        '{OP_WR,  12'h110, 32'hFF,        32'h0,         4'd10}, // R10
        '{OP_RD,  12'h110, 32'h0,         32'h1,         4'd10}, // R10
        '{OP_PL,  12'h000, 32'h1,         32'h0,         4'd10}, // R10
        '{OP_PL,  12'h000, 32'h1,         32'h0,         4'd10}, // R10
        '{OP_RD,  12'h110, 32'h0,         32'h0,         4'd10}, // R10
        '{OP_RD,  12'h030, 32'h0,         32'h0,         4'd11}, // R11
        '{OP_WR,  12'h030, 32'hFFFF_FFFF, 32'h0,         4'd11}, // R11
        '{OP_RD,  12'h030, 32'h0,         32'h0,         4'd11}, // R11
        '{OP_RD,  12'h004, 32'h0,         32'h0,         4'd11}, // R11
        '{OP_RD,  12'h200, 32'h0,         32'h0,         4'd11}, // R11
        '{OP_RD,  12'h118, 32'h0,         32'h0,         4'd11}, // R11
        '{OP_RD,  12'h128, 32'h0,         32'h0,         4'd11}, // R11
        '{OP_RD,  12'h018, 32'h0,         32'h0,         4'd11}, // R11
        '{OP_RD,  12'h000, 32'h0,         32'h00C0_0002, 4'd11}  // R11
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [11:0]    bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] done_i = '0;
    logic           irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cop_regbank #(
        .NCH       (NCH),
        .ADDR_W    (12),
        .CHEN_W    (8),
        .CAP_VALUE (CAP)
    ) u_cop_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done_i    (done_i),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at a falling edge, commit on the rising edge, release
    task automatic cycle(input logic wr, input logic rd, input logic [11:0] addr,
                         input logic [31:0] wd, input logic [NCH-1:0] dn);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd; done_i = dn;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; done_i = '0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] addr, input logic [31:0] exp);
        cycle(1'b0, 1'b1, addr, '0, '0);
        check(req, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();

        // R1: reset state
        check("R1", 32'(irq_o), 32'h0);
        rd_check("R1", 12'h000, 32'h0);
        rd_check("R1", 12'h010, 32'h0);
        rd_check("R1", 12'h020, 32'h0);
        rd_check("R1", 12'h050, 32'h0);
        rd_check("R1", 12'h100, 32'h0);
        rd_check("R1", 12'h110, 32'h0);
        rd_check("R1", 12'h120, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            case (VECS[i].op)
                OP_WR:  cycle(1'b1, 1'b0, VECS[i].addr, VECS[i].data, '0);
                OP_RD:  rd_check(tag, VECS[i].addr, VECS[i].exp);
                OP_PL:  cycle(1'b0, 1'b0, '0, '0, VECS[i].data[NCH-1:0]);
                default: begin
                    @(negedge clk);
                    check(tag, 32'(irq_o), VECS[i].exp);
                end
            endcase
        end

        // R8: pulse and global clear on the same bit in one cycle
        cycle(1'b0, 1'b0, '0, '0, 4'b0100);
        cycle(1'b1, 1'b0, 12'h018, 32'hFFFF_FFFF, 4'b0100);
        rd_check("R8", 12'h010, 32'h4);
        // R8: pulse and channel-2 clear in one cycle
        cycle(1'b1, 1'b0, 12'h1A8, 32'h1, 4'b0100);
        rd_check("R8", 12'h1A0, 32'h1);
        // R7: a plain channel clear afterwards does take effect
        cycle(1'b1, 1'b0, 12'h1A8, 32'h1, 4'b0000);
        rd_check("R7", 12'h1A0, 32'h0);
        // R10: write plus pulse while the count is zero -> no decrement
        cycle(1'b1, 1'b0, 12'h150, 32'h2, 4'b0010);
        rd_check("R10", 12'h150, 32'h2);
        // R10: write plus pulse while the count is nonzero -> both apply
        cycle(1'b1, 1'b0, 12'h150, 32'h5, 4'b0010);
        rd_check("R10", 12'h150, 32'h6);

        // R1: reset in the middle of a run
        do_reset();
        @(negedge clk);
        check("R1", 32'(irq_o), 32'h0);
        rd_check("R1", 12'h000, 32'h0);
        rd_check("R1", 12'h010, 32'h0);
        rd_check("R1", 12'h140, 32'h0);
        rd_check("R1", 12'h150, 32'h0);
        rd_check("R1", 12'h040, CAP);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule